// File: doc/BRIEF.md
# Raster Byte Fetch and Pixel Serializer

This block turns a byte-packed monochrome frame buffer into a serial pixel stream. Each stored byte covers eight neighbouring pixels. A pointer steps through the buffer one byte at a time, in ascending order. Once in every group of eight visible pixel clocks, the block asks an external memory arbiter for a fetch slot. The arbiter stalls the processor for that one cycle, and the returned byte feeds a shift register that emits one pixel per clock.

Each fetch runs one group ahead of the pixels on screen, so the serializer never waits for data. A frame-start strobe rewinds the pointer. On the cycle after the strobe, the block issues one priming fetch so that the first group of the frame is loaded before the first visible pixel. The arbiter may return the byte in the slot cycle itself or in the cycle after it. Sync generation and the RAM sit outside the block.

Top module: `fb_pixel_serializer`

## Requirements
- R1: While reset is held, `fetch_slot_o` and `pix_o` are 0 and `fetch_addr_o` equals the base address (0x2400 by default).
- R2: A frame-start pulse reloads `fetch_addr_o` to the base address. In the next cycle, `fetch_slot_o` is high for one priming fetch of that address.
- R3: During the visible area, `fetch_slot_o` is high for exactly one clock per group of eight visible pixels. That clock is the seventh pixel of the group (index 6, counting from 0).
- R4: After each fetch slot, the address advances by exactly one, so successive slots present strictly ascending addresses.
- R5: The address stays within a 7168-byte region. After the last byte (base + 7167), the next slot wraps to the base address.
- R6: Visible pixel n of a frame is bit (n mod 8) of the byte fetched for group n/8. Bit 0, the least significant bit, is shown first.
- R7: `pix_o` is 0 on every clock where `vis_i` is low, even when the shift register holds data.
- R8: Outside the visible area, the address and the group position do not change, and no slot is raised apart from the priming slot.
- R9: A byte returned with `fetch_valid_i` in the slot cycle itself is displayed as correctly as one returned in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vis_i | input | 1 | High during visible pixels |
| frame_start_i | input | 1 | One-clock frame-start strobe, given during blanking |
| fetch_data_i | input | 8 | Byte returned by the arbiter |
| fetch_valid_i | input | 1 | Marks `fetch_data_i` as valid |
| fetch_addr_o | output | 16 | Byte address of the current or next fetch |
| fetch_slot_o | output | 1 | Fetch request; the arbiter stalls the processor for this cycle |
| pix_o | output | 1 | Serial monochrome pixel |

## Verification
The checks assume three things about the inputs:
- The frame-start strobe falls in blanking, with at least three blank clocks before the first visible pixel.
- Every visible run is a whole multiple of eight pixels.
- The arbiter answers each slot in the slot cycle or the cycle after it.

The stimulus keeps to these rules. Each frame opens with a strobe followed by four blank clocks. Each line is built from whole bytes. The bench's responder returns the byte at a fixed latency of zero or one, chosen per frame. Under these conditions, the priming fetch always completes before any pixel is shown, and a returned byte never lands outside its group.

// File: rtl/fb_pixel_serializer.sv
module fb_pixel_serializer #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] BASE = 16'h2400,
  parameter int DEPTH = 7168
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vis_i,
  input  logic          frame_start_i,
  input  logic [DW-1:0] fetch_data_i,
  input  logic          fetch_valid_i,
  output logic [AW-1:0] fetch_addr_o,
  output logic          fetch_slot_o,
  output logic          pix_o
);
  localparam int PW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [PW-1:0] SLOT_PH = PW'(DW - 2);
  localparam logic [PW-1:0] LOAD_PH = PW'(DW - 1);
  localparam logic [AW-1:0] LAST = BASE + AW'(DEPTH - 1);

  logic [PW-1:0] phase;
  logic [AW-1:0] ptr;
  logic          prime;
  logic [DW-1:0] hold, shreg;

  assign fetch_slot_o = prime | (vis_i & (phase == SLOT_PH));
  assign fetch_addr_o = ptr;
  assign pix_o        = vis_i & shreg[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
      ptr   <= BASE;
      prime <= 1'b0;
    end else begin
      prime <= frame_start_i;
      if (frame_start_i) begin
        phase <= '0;
        ptr   <= BASE;
      end else begin
        if (vis_i) phase <= (phase == LOAD_PH) ? '0 : phase + PW'(1);
        if (fetch_slot_o) ptr <= (ptr == LAST) ? BASE : ptr + AW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold  <= '0;
      shreg <= '0;
    end else begin
      if (fetch_valid_i) hold <= fetch_data_i;
      if (vis_i) begin
        if (phase == LOAD_PH) shreg <= fetch_valid_i ? fetch_data_i : hold;
        else                  shreg <= shreg >> 1;
      end else if (fetch_valid_i) begin
        shreg <= fetch_data_i;
      end
    end
  end
endmodule

// File: rtl/fb_pixel_serializer_chk.sv
module fb_pixel_serializer_chk #(
  parameter int AW = 16,
  parameter logic [AW-1:0] BASE = 16'h2400,
  parameter int DEPTH = 7168
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vis_i,
  input logic          frame_start_i,
  input logic          fetch_slot_o,
  input logic [AW-1:0] fetch_addr_o,
  input logic          pix_o
);
  localparam logic [AW-1:0] LAST = BASE + AW'(DEPTH - 1);

  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!fetch_slot_o && !pix_o);
    end
  end

  assert_prime_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i |=> (fetch_slot_o && fetch_addr_o == BASE));

  assert_blank_slot_is_prime_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_slot_o && !vis_i) |-> $past(frame_start_i));

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_slot_o && !frame_start_i && fetch_addr_o != LAST) |=> fetch_addr_o == $past(fetch_addr_o) + AW'(1));

  assert_addr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_slot_o && !frame_start_i && fetch_addr_o == LAST) |=> fetch_addr_o == BASE);

  assert_addr_in_region_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_addr_o >= BASE && fetch_addr_o <= LAST);

  assert_dark_in_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !vis_i |-> !pix_o);

  assert_addr_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!vis_i && !fetch_slot_o && !frame_start_i) |=> $stable(fetch_addr_o));
endmodule

bind fb_pixel_serializer fb_pixel_serializer_chk #(.AW(AW), .BASE(BASE), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .vis_i(vis_i), .frame_start_i(frame_start_i),
  .fetch_slot_o(fetch_slot_o), .fetch_addr_o(fetch_addr_o), .pix_o(pix_o)
);

// File: tb/sim_fb_pixel_serializer.sv
module sim_fb_pixel_serializer;
  localparam int CLK_NS = 10;
  localparam logic [15:0] BASE = 16'h2400;
  localparam int DEPTH = 7168;
  localparam logic [15:0] LAST = BASE + 16'(DEPTH - 1);
  // each row: bytes per line, lines, blank clocks, return latency
  localparam int VEC [4][4] = '{'{2, 3, 5, 1}, '{4, 2, 3, 0}, '{1, 4, 2, 1}, '{3, 3, 8, 0}};

  logic clk = 0, rst_n = 0, vis = 0, frame_start = 0, fetch_valid = 0;
  logic [7:0] fetch_data = 0;
  logic [15:0] fetch_addr;
  logic fetch_slot, pix;

  int checks = 0, fails = 0, lat = 1;
  logic pend_v = 0;
  logic [7:0] pend_d = 0;
  logic [15:0] exp_addr = BASE, seen_addr;
  logic seen_slot, seen_pix;

  always #(CLK_NS / 2) clk = ~clk;

  fb_pixel_serializer u0 (
    .clk(clk), .rst_n(rst_n), .vis_i(vis), .frame_start_i(frame_start),
    .fetch_data_i(fetch_data), .fetch_valid_i(fetch_valid),
    .fetch_addr_o(fetch_addr), .fetch_slot_o(fetch_slot), .pix_o(pix)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + (a >> 5) + 11) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input logic v, input logic fs);
    @(negedge clk);
    vis = v; frame_start = fs;
    fetch_valid = pend_v; fetch_data = pend_d; pend_v = 0;
    #1;
    seen_slot = fetch_slot; seen_addr = fetch_addr; seen_pix = pix;
    if (seen_slot) begin
      if (lat == 0) begin fetch_valid = 1; fetch_data = pat(int'(seen_addr)); end
      else begin pend_v = 1; pend_d = pat(int'(seen_addr)); end
      check(seen_addr == exp_addr, (exp_addr == BASE) ? "R5" : "R4", "slot address", int'(seen_addr), int'(exp_addr));
      exp_addr = (exp_addr == LAST) ? BASE : exp_addr + 16'd1;
    end
  endtask

  task automatic run_frame(input int bpl, input int lines, input int blank, input int latency);
    int bidx = 0;
    logic [15:0] frozen;
    lat = latency;
    exp_addr = BASE;
    tick(0, 1);
    check(seen_slot == 0, "R8", "slot on strobe clock", int'(seen_slot), 0);
    tick(0, 0);
    check(seen_slot == 1 && seen_addr == BASE, "R2", "priming slot", int'(seen_addr), int'(BASE));
    for (int i = 0; i < 3; i++) begin
      tick(0, 0);
      check(seen_slot == 0, "R8", "slot before visible", int'(seen_slot), 0);
      check(seen_pix == 0, "R7", "pixel before visible", int'(seen_pix), 0);
    end
    for (int l = 0; l < lines; l++) begin
      for (int n = 0; n < bpl * 8; n++) begin
        int a;
        logic eb;
        tick(1, 0);
        a = int'(BASE) + ((bidx + n / 8) % DEPTH);
        eb = pat(a)[n % 8];
        check(seen_pix == eb, (latency == 0) ? "R9" : "R6", "pixel", int'(seen_pix), int'(eb));
        check(seen_slot == ((n % 8) == 6), "R3", "slot position", int'(seen_slot), int'((n % 8) == 6));
      end
      bidx += bpl;
      for (int b = 0; b < blank; b++) begin
        tick(0, 0);
        if (b == 0) frozen = seen_addr;
        check(seen_pix == 0, "R7", "pixel in blank", int'(seen_pix), 0);
        check(seen_slot == 0 && seen_addr == frozen, "R8", "address in blank", int'(seen_addr), int'(frozen));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    vis = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check(fetch_slot == 0 && pix == 0, "R1", "outputs in reset", int'({fetch_slot, pix}), 0);
    check(fetch_addr == BASE, "R1", "address in reset", int'(fetch_addr), int'(BASE));
    vis = 0;
    @(negedge clk); rst_n = 1;

    for (int k = 0; k < 4; k++) run_frame(VEC[k][0], VEC[k][1], VEC[k][2], VEC[k][3]);

    // full region: final look-ahead slot wraps to the base address (R5)
    run_frame(32, 224, 4, 1);
    check(exp_addr == BASE + 16'd1, "R5", "wrap bookkeeping", int'(exp_addr), int'(BASE + 16'd1));

    // reset in the middle of a line (R1)
    run_frame(2, 1, 2, 1);
    tick(1, 0);
    @(negedge clk); rst_n = 0; vis = 1; fetch_valid = 0; pend_v = 0;
    @(negedge clk); #1;
    check(fetch_addr == BASE && pix == 0 && fetch_slot == 0, "R1", "mid-run reset", int'(fetch_addr), int'(BASE));
    @(negedge clk); rst_n = 1; vis = 0;
    run_frame(1, 2, 3, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule